// File: doc/BRIEF.md
# Multicycle Accumulator CPU Control Unit

This block is a small accumulator machine that shares one memory between code and data. It runs each instruction as a fixed chain of states, and every state performs exactly one register transfer among the program counter, instruction register, memory address register, memory buffer register, accumulator, input latch and memory. All instructions share one three-state prefix that fetches and decodes. The execute phase of each instruction is its own short chain of states that returns to fetch.

A word is 16 bits. The opcode sits in bits 15:12 and the operand address in bits 11:0. The instructions are direct load, add, store, input, a conditional skip, indirect load and store through a pointer held in memory, and halt.

While the core is held in reset, a program port writes the memory. After reset is released, the core runs from address zero. Ports show the program counter, accumulator and halt state, and every memory write the core makes.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_ni` is low, `pc_o` and `ac_o` read zero, `halted_o` and `mem_we_o` are 0, and `prog_we_i` writes `prog_data_i` to memory at `prog_addr_i`. The first cycle after release is the first fetch cycle.
- R2: Every instruction starts with three cycles. Cycle 1 loads the address register from PC. Cycle 2 loads the instruction register from memory and increments PC, so `pc_o` shows PC+1 from cycle 3. Cycle 3 decodes bits 15:12. PC wraps at 12 bits.
- R3: Opcode 1 (load) sets AC to M[X]. Opcode 3 (add) sets AC to AC+M[X] modulo 2^16. Each takes 3 execute cycles, and the new AC is visible in the next fetch cycle.
- R4: Opcode 2 (store) takes 3 execute cycles. In the third cycle `mem_we_o`=1, `mem_addr_o`=X and `mem_wdata_o`=AC. The memory is updated at the end of that cycle.
- R5: Opcode 5 (input) takes 2 execute cycles. It latches `in_data_i` in the first cycle and copies it to AC in the second.
- R6: Opcode E (indirect store) takes 5 execute cycles. In the fifth cycle it writes AC to address M[X][11:0], with `mem_we_o`=1.
- R7: Opcode D (indirect load) takes 5 execute cycles. It sets AC to M[M[X][11:0]].
- R8: Opcode 8 (skip) takes 1 execute cycle and adds one more to PC when the condition in bits 11:10 holds: 00 = AC negative, 01 = AC zero, 10 = AC positive (sign clear and nonzero), 11 = never.
- R9: Opcode 7 (halt) enters a state where `halted_o`=1 and PC and AC hold until reset.
- R10: Opcodes 0, 4, 6, 9, A, B, C and F do nothing and return to fetch right after decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_data_i | input | 16 | External input value |
| prog_we_i | input | 1 | Program port write enable |
| prog_addr_i | input | 12 | Program port address |
| prog_data_i | input | 16 | Program port data |
| halted_o | output | 1 | Core is in the halt state |
| pc_o | output | 12 | Program counter |
| ac_o | output | 16 | Accumulator |
| mem_we_o | output | 1 | Core memory write this cycle |
| mem_addr_o | output | 12 | Memory address register |
| mem_wdata_o | output | 16 | Memory buffer register (write data) |

## Verification
A wrong state transition changes how many cycles an instruction takes. The mismatch shows on `pc_o` at the next fetch, at most one instruction later, or as a write strobe in the wrong cycle. A wrong transfer shows on `ac_o` at the next fetch cycle, or on the write address or data in the cycle of the write. A wrong pointer or stored value shows when a later load reads it back. The reference model predicts all of these ports on every clock, so a divergence is reported in the cycle where it first appears.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int OPC_W  = DATA_W - ADDR_W;

  localparam logic [OPC_W-1:0] OPC_LOAD   = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE  = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ADD    = 4'h3;
  localparam logic [OPC_W-1:0] OPC_INPUT  = 4'h5;
  localparam logic [OPC_W-1:0] OPC_HALT   = 4'h7;
  localparam logic [OPC_W-1:0] OPC_SKIP   = 4'h8;
  localparam logic [OPC_W-1:0] OPC_LOADI  = 4'hD;
  localparam logic [OPC_W-1:0] OPC_STOREI = 4'hE;

  typedef enum logic [4:0] {
    S_FETCH0, S_FETCH1, S_DECODE,
    S_LD0, S_LD1, S_LD2,
    S_ADD0, S_ADD1, S_ADD2,
    S_ST0, S_ST1, S_ST2,
    S_IN0, S_IN1,
    S_SKIP,
    S_LI0, S_LI1, S_LI2, S_LI3, S_LI4,
    S_SI0, S_SI1, S_SI2, S_SI3, S_SI4,
    S_HALT
  } state_e;

  typedef enum logic [3:0] {
    UOP_NONE, UOP_MAR_PC, UOP_IR_MEM, UOP_MAR_IR, UOP_MAR_MBR,
    UOP_MBR_MEM, UOP_MBR_AC, UOP_AC_MBR, UOP_AC_ADD, UOP_MEM_WR,
    UOP_INREG_IN, UOP_AC_INREG, UOP_PC_INC
  } uop_e;
endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [1:0]       cond_i,
  input  logic             ac_neg_i,
  input  logic             ac_zero_i,
  output uop_e             uop_o,
  output logic             halted_o
);
  state_e state_q, state_d;
  logic   skip_take;

  always_comb begin
    unique case (cond_i)
      2'b00:   skip_take = ac_neg_i;
      2'b01:   skip_take = ac_zero_i;
      2'b10:   skip_take = !ac_neg_i && !ac_zero_i;
      default: skip_take = 1'b0;
    endcase
  end

  always_comb begin
    state_d = S_FETCH0;
    unique case (state_q)
      S_FETCH0: state_d = S_FETCH1;
      S_FETCH1: state_d = S_DECODE;
      S_DECODE: begin
        unique case (opcode_i)
          OPC_LOAD:   state_d = S_LD0;
          OPC_STORE:  state_d = S_ST0;
          OPC_ADD:    state_d = S_ADD0;
          OPC_INPUT:  state_d = S_IN0;
          OPC_HALT:   state_d = S_HALT;
          OPC_SKIP:   state_d = S_SKIP;
          OPC_LOADI:  state_d = S_LI0;
          OPC_STOREI: state_d = S_SI0;
          default:    state_d = S_FETCH0;
        endcase
      end
      S_LD0:  state_d = S_LD1;
      S_LD1:  state_d = S_LD2;
      S_ADD0: state_d = S_ADD1;
      S_ADD1: state_d = S_ADD2;
      S_ST0:  state_d = S_ST1;
      S_ST1:  state_d = S_ST2;
      S_IN0:  state_d = S_IN1;
      S_LI0:  state_d = S_LI1;
      S_LI1:  state_d = S_LI2;
      S_LI2:  state_d = S_LI3;
      S_LI3:  state_d = S_LI4;
      S_SI0:  state_d = S_SI1;
      S_SI1:  state_d = S_SI2;
      S_SI2:  state_d = S_SI3;
      S_SI3:  state_d = S_SI4;
      S_HALT: state_d = S_HALT;
      default: state_d = S_FETCH0;
    endcase
  end

  always_comb begin
    unique case (state_q)
      S_FETCH0:                       uop_o = UOP_MAR_PC;
      S_FETCH1:                       uop_o = UOP_IR_MEM;
      S_LD0, S_ADD0, S_ST0,
      S_LI0, S_SI0:                   uop_o = UOP_MAR_IR;
      S_LD1, S_ADD1, S_LI1,
      S_LI3, S_SI1:                   uop_o = UOP_MBR_MEM;
      S_LI2, S_SI2:                   uop_o = UOP_MAR_MBR;
      S_LD2, S_LI4:                   uop_o = UOP_AC_MBR;
      S_ADD2:                         uop_o = UOP_AC_ADD;
      S_ST1, S_SI3:                   uop_o = UOP_MBR_AC;
      S_ST2, S_SI4:                   uop_o = UOP_MEM_WR;
      S_IN0:                          uop_o = UOP_INREG_IN;
      S_IN1:                          uop_o = UOP_AC_INREG;
      S_SKIP:                         uop_o = skip_take ? UOP_PC_INC : UOP_NONE;
      default:                        uop_o = UOP_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_FETCH0;
    else         state_q <= state_d;
  end

  assign halted_o = (state_q == S_HALT);

  AST_FETCH_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_FETCH0 |=> state_q == S_FETCH1); // R2
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_HALT |=> state_q == S_HALT); // R9
  AST_WRITE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uop_o == UOP_MEM_WR |=> state_q == S_FETCH0); // R4
endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
  import acc_cpu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  uop_e              uop_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [OPC_W-1:0]  opcode_o,
  output logic [1:0]        cond_o,
  output logic              ac_neg_o,
  output logic              ac_zero_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ac_o
);
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] ir_q, mbr_q, ac_q, inreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      mar_q   <= '0;
      ir_q    <= '0;
      mbr_q   <= '0;
      ac_q    <= '0;
      inreg_q <= '0;
    end else begin
      unique case (uop_i)
        UOP_MAR_PC:   mar_q   <= pc_q;
        UOP_IR_MEM:   begin ir_q <= mem_rdata_i; pc_q <= pc_q + 1'b1; end
        UOP_MAR_IR:   mar_q   <= ir_q[ADDR_W-1:0];
        UOP_MAR_MBR:  mar_q   <= mbr_q[ADDR_W-1:0];
        UOP_MBR_MEM:  mbr_q   <= mem_rdata_i;
        UOP_MBR_AC:   mbr_q   <= ac_q;
        UOP_AC_MBR:   ac_q    <= mbr_q;
        UOP_AC_ADD:   ac_q    <= ac_q + mbr_q;
        UOP_INREG_IN: inreg_q <= in_data_i;
        UOP_AC_INREG: ac_q    <= inreg_q;
        UOP_PC_INC:   pc_q    <= pc_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign opcode_o  = ir_q[DATA_W-1:ADDR_W];
  assign cond_o    = ir_q[ADDR_W-1:ADDR_W-2];
  assign ac_neg_o  = ac_q[DATA_W-1];
  assign ac_zero_o = (ac_q == '0);
  assign mem_we_o  = (uop_i == UOP_MEM_WR);
  assign mar_o     = mar_q;
  assign mbr_o     = mbr_q;
  assign pc_o      = pc_q;
  assign ac_o      = ac_q;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pc_q) |-> pc_q == $past(pc_q) + 1'b1); // R2
  AST_IR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ir_q) |-> $past(uop_i) == UOP_IR_MEM); // R2
  AST_AC_WRITERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ac_q) |-> $past(uop_i inside {UOP_AC_MBR, UOP_AC_ADD, UOP_AC_INREG})); // R3
endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i[MEM_AW-1:0]] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i[MEM_AW-1:0]];

  generate
    if (MEM_AW < ADDR_W) begin : g_upper
      logic unused_hi;
      assign unused_hi = ^{waddr_i[ADDR_W-1:MEM_AW], raddr_i[ADDR_W-1:MEM_AW]};
    end
  endgenerate
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              prog_we_i,
  input  logic [ADDR_W-1:0] prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  output logic              halted_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] ac_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  uop_e              uop;
  logic [OPC_W-1:0]  opcode;
  logic [1:0]        cond;
  logic              ac_neg, ac_zero, cpu_we;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr, rdata;

  acc_cpu_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .opcode_i (opcode),
    .cond_i   (cond),
    .ac_neg_i (ac_neg),
    .ac_zero_i(ac_zero),
    .uop_o    (uop),
    .halted_o (halted_o)
  );

  acc_cpu_datapath u_dp (
    .clk_i, .rst_ni,
    .uop_i      (uop),
    .in_data_i  (in_data_i),
    .mem_rdata_i(rdata),
    .opcode_o   (opcode),
    .cond_o     (cond),
    .ac_neg_o   (ac_neg),
    .ac_zero_o  (ac_zero),
    .mem_we_o   (cpu_we),
    .mar_o      (mar),
    .mbr_o      (mbr),
    .pc_o       (pc_o),
    .ac_o       (ac_o)
  );

  acc_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_mem (
    .clk_i,
    .we_i   (prog_we_i | cpu_we),
    .waddr_i(prog_we_i ? prog_addr_i : mar),
    .wdata_i(prog_we_i ? prog_data_i : mbr),
    .raddr_i(mar),
    .rdata_o(rdata)
  );

  assign mem_we_o    = cpu_we;
  assign mem_addr_o  = mar;
  assign mem_wdata_o = mbr;
endmodule

// File: tb/acc_cpu_core_bench.sv
module acc_cpu_core_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] in_data_i = '0;
  logic        prog_we_i = 1'b0;
  logic [11:0] prog_addr_i = '0;
  logic [15:0] prog_data_i = '0;
  logic        halted_o, mem_we_o;
  logic [11:0] pc_o, mem_addr_o;
  logic [15:0] ac_o, mem_wdata_o;

  int errors = 0;
  int checks = 0;

  logic [15:0] prog [32];
  logic [15:0] mm   [256];
  logic [11:0] mpc;
  logic [15:0] mac;

  acc_cpu_core u_acc_cpu_core (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [11:0] epc, input logic [15:0] eac,
                     input logic ewe, input logic [11:0] ea, input logic [15:0] ed,
                     input logic ehalt);
    checks++;
    if (pc_o !== epc || ac_o !== eac || mem_we_o !== ewe || halted_o !== ehalt ||
        (ewe && (mem_addr_o !== ea || mem_wdata_o !== ed))) begin
      errors++;
      $display("FAIL %s t=%0t: pc=%h ac=%h we=%b a=%h d=%h halt=%b expected pc=%h ac=%h we=%b a=%h d=%h halt=%b",
               req, $time, pc_o, ac_o, mem_we_o, mem_addr_o, mem_wdata_o, halted_o,
               epc, eac, ewe, ea, ed, ehalt);
    end
  endtask

  task automatic cyc(input string req, input logic ewe = 1'b0,
                     input logic [11:0] ea = '0, input logic [15:0] ed = '0,
                     input logic ehalt = 1'b0);
    chk(req, mpc, mac, ewe, ea, ed, ehalt);
    @(negedge clk_i); #1;
  endtask

  function automatic logic take_skip(input logic [1:0] c, input logic [15:0] a);
    case (c)
      2'b00:   return a[15];
      2'b01:   return a == 16'h0;
      2'b10:   return !a[15] && a != 16'h0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic load_and_run(input logic [15:0] inval);
    rst_ni = 1'b0;
    in_data_i = inval;
    for (int i = 0; i < 256; i++) mm[i] = (i < 32) ? prog[i] : 16'h0;
    mm[8'h81] = 16'h0090; mm[8'h82] = 16'h0080; mm[8'h83] = 16'hFFFF; mm[8'h84] = 16'h0001;
    @(negedge clk_i);
    for (int i = 0; i < 256; i++) begin
      prog_we_i = 1'b1; prog_addr_i = 12'(i); prog_data_i = mm[i];
      @(negedge clk_i);
    end
    prog_we_i = 1'b0;
    #1;
    mpc = '0; mac = '0;
    chk("R1 reset", 12'h0, 16'h0, 1'b0, '0, '0, 1'b0);
    rst_ni = 1'b1;
    #1;
    forever begin
      logic [15:0] ins;
      logic [11:0] x, ptr;
      ins = mm[mpc[7:0]];
      x = ins[11:0];
      cyc("R2 fetch0");
      cyc("R2 fetch1");
      mpc = mpc + 1'b1;
      cyc("R2 decode");
      case (ins[15:12])
        4'h1: begin repeat (3) cyc("R3 load"); mac = mm[x[7:0]]; end
        4'h3: begin repeat (3) cyc("R3 add"); mac = mac + mm[x[7:0]]; end
        4'h2: begin
          repeat (2) cyc("R4 store");
          cyc("R4 store write", 1'b1, x, mac);
          mm[x[7:0]] = mac;
        end
        4'h5: begin repeat (2) cyc("R5 input"); mac = inval; end
        4'h8: begin
          cyc("R8 skip");
          if (take_skip(x[11:10], mac)) mpc = mpc + 1'b1;
        end
        4'hD: begin
          repeat (5) cyc("R7 loadi");
          ptr = mm[x[7:0]][11:0];
          mac = mm[ptr[7:0]];
        end
        4'hE: begin
          repeat (4) cyc("R6 storei");
          ptr = mm[x[7:0]][11:0];
          cyc("R6 storei write", 1'b1, ptr, mac);
          mm[ptr[7:0]] = mac;
        end
        4'h7: begin
          repeat (6) cyc("R9 halt", 1'b0, '0, '0, 1'b1);
          break;
        end
        default: ; // R10: no execute cycles
      endcase
    end
    // R1: reset again from a non-zero state
    rst_ni = 1'b0;
    #1;
    chk("R1 reset after run", 12'h0, 16'h0, 1'b0, '0, '0, 1'b0);
  endtask

  initial begin
    prog = '{default: 16'h0};
    prog[0]  = 16'h5000; // input
    prog[1]  = 16'h2080; // store
    prog[2]  = 16'h3080; // add
    prog[3]  = 16'hE081; // storei
    prog[4]  = 16'hD082; // loadi
    prog[5]  = 16'h8800; // skip if positive
    prog[6]  = 16'h7000;
    prog[7]  = 16'h8000; // skip if negative
    prog[8]  = 16'h1083; // load
    prog[9]  = 16'h8000;
    prog[10] = 16'h7000;
    prog[11] = 16'h8400; // skip if zero
    prog[12] = 16'h8C00; // never
    prog[13] = 16'h3084;
    prog[14] = 16'h8400;
    prog[15] = 16'h7000;
    prog[16] = 16'h4123; // R10 unused opcode
    prog[17] = 16'hD090; // R7 reads back value written by storei
    prog[18] = 16'h7000;
    load_and_run(16'h0005);
    load_and_run(16'h8000); // R3 add wraps to zero, R8 positive not taken
    load_and_run(16'h0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule